// File: doc/BRIEF.md
# Quad SPI Flash Read Master

This block sits on the host side of a serial NOR flash. It turns word-read requests into flash read transactions. A client holds `req_valid` high together with a 24-bit byte address. The block answers with a one-cycle `req_ready` pulse, and `req_rdata` carries the 32-bit word stored at that address and the three addresses after it. On the flash side it drives chip select, a serial clock at half the system clock rate, and four data lines. Each data line has its own output value and output enable, and the returned value arrives separately on `io_in`.

After reset the block wakes the flash and then serves reads in one of three ways, chosen per transaction by `cfg_mode`:
- a single-line read;
- a four-line read with a dummy cycle;
- a four-line read that moves a nibble on every clock edge.

When `cfg_cont` is set in a four-line mode, the block asks the flash to stay in continuous-read mode. Later transactions then leave out the command byte. After each word the block keeps chip select low. If the next request asks for the following word, the block just clocks out more data. Any other address closes the transaction.

Top module: `qspi_flash_reader`

## Requirements
- R1: After reset, and before any request is served, the block sends two transactions, each carrying only a single-line command byte on line 0: first 0xFF, then 0xAB.
- R2: `cfg_mode` = 0 (and 3) selects single-line read:
  - command 0x03 and then 24 address bits go out MSB first on line 0, with no mode byte and no dummy cycle;
  - 32 data bits are then taken from line 1, one bit on each rising clock edge.
- R3: `cfg_mode` = 1 selects four-line read:
  - command 0xEB goes out on line 0;
  - the 24-bit address and then a mode byte go out four bits per clock, high nibble first, with byte bit 7 on line 3 and bit 4 on line 0;
  - one dummy clock follows, during which all host enables are low;
  - data nibbles are taken on rising edges.
- R4: `cfg_mode` = 2 selects double-rate read:
  - command 0xED goes out single-line;
  - address, mode byte and data then move one nibble per clock edge, the high nibble on the rising edge and the low nibble on the falling edge;
  - one dummy clock separates the mode byte from the data.
- R5: The mode byte is 0xA5 only when `cfg_cont` is 1 and the transaction uses the four-line mode that `cfg_mode` selects. In every other four-line transaction it is 0xFF.
- R6: After a transaction that sent 0xA5, the next transaction sends no command and starts with the address, in the same four-line mode as the 0xA5 transaction. That mode is kept even if `cfg_mode` has changed since. When the configuration no longer asks for that mode, this transaction carries mode byte 0xFF.
- R7: The four received bytes come from ascending addresses, and the first byte lands in `req_rdata[7:0]`. The address wraps from 0xFFFFFF to 0.
- R8: Chip select stays low after a word. If the next request address equals the previous one plus 4 (modulo 2^24), more data clocks are sent in the open transaction. Any other address raises chip select and starts a new transaction.
- R9: `req_ready` is high for exactly one cycle per served request, and only while chip select is low. A request is taken only while the block is idle, and never in the cycle in which `req_ready` is high.
- R10: While chip select is high, all four output enables are low and the serial clock is low.
- R11: The serial clock toggles at most once per system cycle. Chip select stays high for at least `GAP_CYC` (default 2) cycles between transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Read style: 0 single-line, 1 four-line, 2 four-line double rate, 3 as 0 |
| cfg_cont | input | 1 | Ask the flash to stay in continuous-read mode |
| req_valid | input | 1 | Read request; held with the address until `req_ready` |
| req_addr | input | 24 | Byte address of the requested word |
| req_ready | output | 1 | One-cycle pulse: `req_rdata` is valid |
| req_rdata | output | 32 | Little-endian word read from the flash |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | Values driven on the four data lines |
| io_oe | output | 4 | Per-line output enables |
| io_in | input | 4 | Values seen on the four data lines |

## Verification
The assertions rely on the client protocol:
- `req_valid` and `req_addr` stay steady from the cycle they are raised until `req_ready` is seen;
- `cfg_mode` and `cfg_cont` change only while no request is pending.

The bench drives every request on a falling system-clock edge and holds it until it observes the ready pulse. It changes the configuration only between requests. The flash model in the bench never drives a line in the same cycle that the host enables that line, so `io_in` always reflects exactly one driver.

// File: rtl/qspi_flash_reader.sv
module qspi_flash_reader #(
  parameter int GAP_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_mode,
  input  logic        cfg_cont,
  input  logic        req_valid,
  input  logic [23:0] req_addr,
  output logic        req_ready,
  output logic [31:0] req_rdata,
  output logic        cs_n,
  output logic        sck,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  typedef enum logic [2:0] {S_GAP, S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_HOLD} state_t;
  localparam logic [1:0] M_QUAD = 2'd1;
  localparam logic [1:0] M_DDR  = 2'd2;
  localparam int GW = $clog2(GAP_CYC + 1);

  state_t        st;
  logic          ph;
  logic [5:0]    cnt;
  logic [GW-1:0] gap;
  logic [1:0]    init_step, tmode, cont_mode;
  logic          cont_act;
  logic [31:0]   tx, hdr, rx;
  logic [23:0]   nxt;

  function automatic logic [5:0] addr_last(input logic [1:0] m);
    case (m)
      M_QUAD:  return 6'd7;
      M_DDR:   return 6'd3;
      default: return 6'd23;
    endcase
  endfunction

  wire       quad   = tmode == M_QUAD;
  wire       ddr    = tmode == M_DDR;
  wire       wide   = quad | ddr;
  wire [1:0] emode  = cont_act ? cont_mode : cfg_mode;
  wire       e_wide = emode == M_QUAD || emode == M_DDR;
  wire       keep   = cfg_cont && e_wide && cfg_mode == emode;
  wire [7:0] mbyte  = keep ? 8'hA5 : 8'hFF;
  wire [7:0] rcmd   = emode == M_QUAD ? 8'hEB : emode == M_DDR ? 8'hED : 8'h03;
  wire       take   = req_valid && !req_ready;
  wire [5:0] dlen   = ddr ? 6'd3 : quad ? 6'd7 : 6'd31;

  assign sck       = ph;
  assign io_oe     = st == S_CMD ? 4'b0001 : st == S_ADDR ? (wide ? 4'b1111 : 4'b0001) : 4'b0000;
  assign io_out    = (st == S_ADDR && wide) ? tx[31:28] : {3'b000, tx[31]};
  assign req_rdata = {rx[7:0], rx[15:8], rx[23:16], rx[31:24]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_GAP; ph <= 1'b0; cnt <= '0; gap <= '0; init_step <= '0;
      tmode <= '0; cont_act <= 1'b0; cont_mode <= '0;
      tx <= '0; hdr <= '0; rx <= '0; nxt <= '0;
      cs_n <= 1'b1; req_ready <= 1'b0;
    end else begin
      req_ready <= 1'b0;
      case (st)
        S_GAP:
          if (gap == GW'(GAP_CYC - 1)) begin
            gap <= '0;
            if (init_step != 2'd2) begin
              cs_n  <= 1'b0;
              tmode <= 2'd0;
              tx    <= {(init_step == 2'd0) ? 8'hFF : 8'hAB, 24'h0};
              cnt   <= 6'd7;
              st    <= S_CMD;
            end else st <= S_IDLE;
          end else gap <= gap + 1'b1;
        S_IDLE:
          if (take) begin
            cs_n      <= 1'b0;
            tmode     <= emode;
            hdr       <= {req_addr, mbyte};
            nxt       <= req_addr + 24'd4;
            cont_act  <= keep;
            cont_mode <= emode;
            if (cont_act) begin
              tx  <= {req_addr, mbyte};
              cnt <= addr_last(emode);
              st  <= S_ADDR;
            end else begin
              tx  <= {rcmd, 24'h0};
              cnt <= 6'd7;
              st  <= S_CMD;
            end
          end
        S_CMD, S_ADDR, S_DUMMY, S_DATA: begin
          ph <= ~ph;
          if (!ph) begin
            if (st == S_DATA) rx <= wide ? {rx[27:0], io_in} : {rx[30:0], io_in[1]};
            if (st == S_ADDR && ddr) tx <= tx << 4;
          end else begin
            if (st == S_DATA && ddr) rx <= {rx[27:0], io_in};
            if (st == S_CMD || (st == S_ADDR && !wide)) tx <= tx << 1;
            else if (st == S_ADDR) tx <= tx << 4;
            cnt <= cnt - 1'b1;
            if (cnt == 6'd0) begin
              case (st)
                S_CMD:
                  if (init_step != 2'd2) begin
                    cs_n      <= 1'b1;
                    st        <= S_GAP;
                    init_step <= init_step + 1'b1;
                  end else begin
                    tx  <= hdr;
                    cnt <= addr_last(tmode);
                    st  <= S_ADDR;
                  end
                S_ADDR:
                  if (wide) begin
                    cnt <= 6'd0;
                    st  <= S_DUMMY;
                  end else begin
                    cnt <= dlen;
                    st  <= S_DATA;
                  end
                S_DUMMY: begin
                  cnt <= dlen;
                  st  <= S_DATA;
                end
                default: begin
                  req_ready <= 1'b1;
                  st        <= S_HOLD;
                end
              endcase
            end
          end
        end
        S_HOLD:
          if (take) begin
            if (req_addr == nxt) begin
              nxt <= nxt + 24'd4;
              cnt <= dlen;
              st  <= S_DATA;
            end else begin
              cs_n <= 1'b1;
              st   <= S_GAP;
            end
          end
        default: st <= S_GAP;
      endcase
    end
  end

  // R10
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> io_oe == 4'b0000);
  // R10
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R11
  sck_half_chk: assert property (@(posedge clk) disable iff (!rst_n) sck |=> !sck);
  // R11
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n);
  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready |=> !req_ready);
  // R9
  ready_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !cs_n);
endmodule

// File: tb/test_qspi_flash_reader.sv
module test_qspi_flash_reader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_cont = 1'b0, req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic req_ready, cs_n, sck;
  logic [31:0] req_rdata;
  logic [3:0] io_out, io_oe, io_in;
  logic [3:0] fl_out = '0, fl_oe = '0;

  int n_checks = 0, n_err = 0, cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign io_in = (fl_oe & fl_out) | (~fl_oe & ((io_oe & io_out) | ~io_oe));

  qspi_flash_reader i_qspi_flash_reader (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cont(cfg_cont),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .req_rdata(req_rdata), .cs_n(cs_n), .sck(sck), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in)
  );

  function automatic logic [7:0] mem(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
  endfunction

  function automatic logic [31:0] word(input logic [23:0] a);
    return {mem(a + 24'd3), mem(a + 24'd2), mem(a + 24'd1), mem(a)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // behavioural flash: sampled once per system cycle
  localparam int P_OFF = 0, P_CMD = 1, P_SADDR = 2, P_QADDR = 3, P_DADDR = 4,
                 P_DUM = 5, P_SDATA = 6, P_QDATA = 7, P_DDATA = 8, P_IGN = 9;
  int ph_m = P_OFF, nb = 0, ocnt = 0, trans_cnt = 0, hi_run = 0;
  logic [31:0] sh = '0;
  logic [23:0] fa = '0;
  logic [7:0] ob = '0;
  logic powered = 1'b0, dum_ddr = 1'b0;
  logic [1:0] xip = 2'd0;
  logic last_cs = 1'b1, last_sck = 1'b0, last_rdy = 1'b0;
  logic [3:0] io_d = '0;
  logic [7:0] cmd_q[$];
  logic [7:0] mb_q[$];

  always @(negedge clk) begin
    logic rise, fall;
    rise = !last_sck && sck;
    fall = last_sck && !sck;
    if (rst_n) begin
      if (cs_n) check(io_oe == 4'b0000 && !sck, "R10 idle lines", {27'b0, sck, io_oe}, 32'h0);
      check(!(last_sck && sck), "R11 sck rate", {31'b0, sck}, 32'h0);
      check(!(last_rdy && req_ready), "R9 ready width", {31'b0, req_ready}, 32'h0);
      check((io_oe & fl_oe) == 4'b0000, "R3 bus conflict", {24'b0, io_oe, fl_oe}, 32'h0);
      if (!cs_n && last_cs) check(hi_run >= 2, "R11 cs gap", hi_run, 32'd2);
    end
    hi_run = cs_n ? hi_run + 1 : 0;
    if (!cs_n && last_cs) begin
      trans_cnt++; sh = '0; nb = 0; fl_oe = '0;
      ph_m = xip == 2'd1 ? P_QADDR : xip == 2'd2 ? P_DADDR : P_CMD;
    end else if (cs_n && !last_cs) begin
      fl_oe = '0; ph_m = P_OFF;
    end else if (!cs_n && rise) begin
      case (ph_m)
        P_CMD: begin
          sh = {sh[30:0], io_d[0]}; nb++;
          if (nb == 8) begin
            cmd_q.push_back(sh[7:0]); nb = 0; sh = '0;
            case (sh[7:0] | cmd_q[$])
              8'hFF: begin xip = 2'd0; ph_m = P_IGN; end
              8'hAB: begin powered = 1'b1; ph_m = P_IGN; end
              8'h03: ph_m = powered ? P_SADDR : P_IGN;
              8'hEB: ph_m = powered ? P_QADDR : P_IGN;
              8'hED: ph_m = powered ? P_DADDR : P_IGN;
              default: ph_m = P_IGN;
            endcase
          end
        end
        P_SADDR: begin
          sh = {sh[30:0], io_d[0]}; nb++;
          if (nb == 24) begin
            fa = sh[23:0]; ob = mem(fa); ocnt = 0; ph_m = P_SDATA;
          end
        end
        P_QADDR, P_DADDR: begin
          sh = {sh[27:0], io_d}; nb++;
        end
        P_DUM: begin
          check(io_oe == 4'b0000, "R3 dummy release", {28'b0, io_oe}, 32'h0);
          ph_m = dum_ddr ? P_DDATA : P_QDATA;
        end
        P_DDATA: begin
          fl_oe = 4'hF; fl_out = ob[7:4]; ob = {ob[3:0], 4'h0}; ocnt++;
          if (ocnt == 2) begin fa = fa + 24'd1; ob = mem(fa); ocnt = 0; end
        end
        default: ;
      endcase
    end else if (!cs_n && fall) begin
      case (ph_m)
        P_DADDR:
          if (nb % 2 == 1) begin sh = {sh[27:0], io_d}; nb++; end
        P_SDATA: begin
          fl_oe = 4'b0010; fl_out = {2'b00, ob[7], 1'b0}; ob = {ob[6:0], 1'b0}; ocnt++;
          if (ocnt == 8) begin fa = fa + 24'd1; ob = mem(fa); ocnt = 0; end
        end
        P_QDATA, P_DDATA: begin
          fl_oe = 4'hF; fl_out = ob[7:4]; ob = {ob[3:0], 4'h0}; ocnt++;
          if (ocnt == 2) begin fa = fa + 24'd1; ob = mem(fa); ocnt = 0; end
        end
        default: ;
      endcase
    end
    if ((ph_m == P_QADDR || ph_m == P_DADDR) && nb == 8) begin
      fa = sh[31:8]; mb_q.push_back(sh[7:0]);
      dum_ddr = ph_m == P_DADDR;
      xip = sh[7:0] == 8'hA5 ? (dum_ddr ? 2'd2 : 2'd1) : 2'd0;
      ob = mem(fa); ocnt = 0; nb = 0; ph_m = P_DUM;
    end
    io_d = io_in; last_cs = cs_n; last_sck = sck; last_rdy = req_ready;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      check(1'b0, "watchdog", cyc, 100000);
      finish_run;
    end
  end

  task automatic do_read(input logic [23:0] a, input string tag);
    int w = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    do begin @(negedge clk); w++; end while (!req_ready && w < 5000);
    req_valid = 1'b0;
    check(req_ready && req_rdata == word(a), tag, req_rdata, word(a));
  endtask

  int tc, cc;

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && io_oe == 4'b0 && req_ready == 1'b0, "R10 reset state",
          {29'b0, cs_n, req_ready, |io_oe}, 32'h4);
    rst_n = 1'b1;

    // R1 and R2: the first request waits for the wake-up sequence
    do_read(24'h000100, "R2 single read");
    check(cmd_q.size() == 3, "R1 command count", cmd_q.size(), 3);
    check(cmd_q[0] == 8'hFF, "R1 first command", cmd_q[0], 8'hFF);
    check(cmd_q[1] == 8'hAB, "R1 second command", cmd_q[1], 8'hAB);
    check(cmd_q[2] == 8'h03, "R2 read command", cmd_q[2], 8'h03);

    tc = trans_cnt;
    do_read(24'h000104, "R8 sequential single");
    check(trans_cnt == tc, "R8 stream kept open", trans_cnt, tc);
    do_read(24'h000200, "R8 jump single");
    check(trans_cnt == tc + 1, "R8 jump reopens", trans_cnt, tc + 1);

    cfg_mode = 2'd1;
    do_read(24'h001000, "R3 quad read");
    check(cmd_q[$] == 8'hEB, "R3 quad command", cmd_q[$], 8'hEB);
    check(mb_q[$] == 8'hFF, "R5 mode byte plain", mb_q[$], 8'hFF);

    cfg_cont = 1'b1;
    do_read(24'h002000, "R5 quad keep");
    check(mb_q[$] == 8'hA5, "R5 mode byte keep", mb_q[$], 8'hA5);
    cc = cmd_q.size(); tc = trans_cnt;
    do_read(24'h003000, "R6 quad no command");
    check(cmd_q.size() == cc && trans_cnt == tc + 1, "R6 command skipped", cmd_q.size(), cc);
    do_read(24'h003004, "R8 quad stream");
    check(trans_cnt == tc + 1, "R8 quad stream open", trans_cnt, tc + 1);

    cfg_mode = 2'd2;
    do_read(24'h004000, "R6 exit transaction");
    check(cmd_q.size() == cc && mb_q[$] == 8'hFF, "R6 exit mode byte", mb_q[$], 8'hFF);
    do_read(24'h005000, "R4 ddr read");
    check(cmd_q[$] == 8'hED && mb_q[$] == 8'hA5, "R4 ddr command", cmd_q[$], 8'hED);
    cc = cmd_q.size();
    do_read(24'h006000, "R6 ddr no command");
    check(cmd_q.size() == cc, "R6 ddr command skipped", cmd_q.size(), cc);
    cfg_cont = 1'b0;
    do_read(24'h007000, "R5 ddr release");
    check(cmd_q.size() == cc && mb_q[$] == 8'hFF, "R5 ddr release byte", mb_q[$], 8'hFF);
    do_read(24'h008000, "R4 ddr plain");
    check(cmd_q[$] == 8'hED && cmd_q.size() == cc + 1, "R4 ddr command again", cmd_q[$], 8'hED);
    tc = trans_cnt;
    do_read(24'h008004, "R4 ddr stream");
    check(trans_cnt == tc, "R8 ddr stream open", trans_cnt, tc);

    cfg_mode = 2'd0;
    do_read(24'hFFFFFC, "R7 top of memory");
    tc = trans_cnt;
    do_read(24'h000000, "R7 wrap stream");
    check(trans_cnt == tc, "R8 wrap stream open", trans_cnt, tc);
    cfg_mode = 2'd1;
    do_read(24'h000123, "R7 odd address order");

    repeat (10) @(negedge clk);
    finish_run;
  end
endmodule